// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block sits between a readout controller and a dual-channel sampling converter and owns the converter's power state. The converter has no register port for power control. A low-power mode is commanded by a burst of convert pulses while the serial clock stays still: two pulses select nap and four select sleep. Serial-clock pulses bring the converter back. After sleep the converter's reference must settle before any sample can be trusted.

A power request arrives on a valid/ready handshake. A request moves only when `req_valid` and `req_ready` are both high on a rising clock edge. `req_ready` is high only while the sequencer rests in a steady mode. During a command, a wake pulse or a settling wait it stays low, and the requester must hold its request until it is taken. While the converter is active, the readout controller drives the converter lines through the block and `rd_grant` is high. In every other state the block drives the lines itself and ignores the readout controller. The reference wait is a cycle count derived from the clock frequency and the settling time, both given as parameters.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset `rd_grant` is 1, `req_ready` is 1, `cur_mode` is 2'b00 (active) and the converter lines follow the readout lines.
- R2: While `rd_grant` is 1, `adc_conv` equals `rd_conv` and `adc_sck` equals `rd_sck` in the same cycle.
- R3: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after a taken request that starts a command, wake or wait until that activity ends. A request presented while `req_ready` is 0 has no effect.
- R4: A nap request (`req_mode` 2'b01) from active produces exactly 2 convert pulses with `adc_sck` held at 0, and the sequencer then rests in nap with `cur_mode` 2'b01.
- R5: A sleep request (`req_mode` 2'b10) from active or from nap produces exactly 4 convert pulses with `adc_sck` held at 0, and the sequencer then rests in sleep with `cur_mode` 2'b10.
- R6: Every generated pulse on `adc_conv` or `adc_sck` is high for exactly PULSE_CYC cycles, and consecutive convert pulses are separated by exactly PULSE_CYC low cycles.
- R7: While `rd_grant` is 0, `rd_conv` and `rd_sck` have no effect on `adc_conv` or `adc_sck`, and in a resting nap or sleep state both converter lines are 0.
- R8: `rd_grant` is 0 from the cycle after a taken request that leaves active until the sequencer is again resting in active.
- R9: An active request (2'b00) in nap sends one `adc_sck` pulse with `adc_conv` at 0. No settling wait follows: `rd_grant` returns within PULSE_CYC+2 cycles after `adc_sck` falls.
- R10: An active request in sleep sends one `adc_sck` pulse. `rd_grant` then returns no sooner than SETTLE_CYC and no later than SETTLE_CYC+2*PULSE_CYC+2 cycles after `adc_sck` falls, where SETTLE_CYC = CLK_KHZ*SETTLE_US/1000.
- R11: A nap request in sleep wakes with one `adc_sck` pulse, waits SETTLE_CYC cycles, then sends 2 convert pulses and rests in nap. `rd_grant` stays 0 throughout.
- R12: A request for the current mode, or the code 2'b11, is taken at once and causes no pulse, no change of `cur_mode` and no change of `rd_grant`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Power request present |
| req_mode | input | 2 | Requested mode: 00 active, 01 nap, 10 sleep, 11 no change |
| req_ready | output | 1 | Sequencer can take a request |
| cur_mode | output | 2 | Mode the converter last settled in (same encoding) |
| rd_conv | input | 1 | Convert line from the readout controller |
| rd_sck | input | 1 | Serial clock from the readout controller |
| rd_grant | output | 1 | Readout controller owns the converter lines |
| adc_conv | output | 1 | Convert line to the converter |
| adc_sck | output | 1 | Serial clock to the converter |

## Verification
The bench counts pulses and pulse widths on both converter lines for every transition. A design that sent three pulses, or let the serial clock move during a burst, would put the converter in the wrong mode. It measures the distance from the wake pulse to the return of the grant. This catches a nap wake that waits for the reference and a sleep wake that hands the lines back early. Readout lines are held high during commands and resting states, so a mux leak shows up as extra or stretched pulses. A request presented mid-command and a same-mode request check that the sequencer neither aborts a burst nor emits stray pulses.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_NAP    = 2'b01,
    PM_SLEEP  = 2'b10,
    PM_KEEP   = 2'b11
  } pm_mode_e;

  typedef enum logic [2:0] {
    ST_ACT,
    ST_NAP,
    ST_SLP,
    ST_CMD,
    ST_WAKE,
    ST_SETTLE
  } seq_st_e;

endpackage

// File: rtl/pm_pulse_train.sv
module pm_pulse_train #(
  parameter int PULSE_CYC  = 2,
  parameter int MAX_PULSES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [$clog2(MAX_PULSES+1)-1:0]   num_i,
  output logic                              line_o,
  output logic                              busy_o,
  output logic                              done_o
);
  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(2 * PULSE_CYC) : 1;
  localparam logic [PW-1:0] PH_HI   = PW'(PULSE_CYC);
  localparam logic [PW-1:0] PH_LAST = PW'(2 * PULSE_CYC - 1);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [PW-1:0] ph_q;
  logic [CW-1:0] rem_q;
  logic          busy_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        ph_q   <= '0;
        rem_q  <= num_i;
        busy_q <= (num_i != '0);
      end else if (busy_q) begin
        if (ph_q == PH_LAST) begin
          ph_q  <= '0;
          rem_q <= rem_q - ONE;
          if (rem_q == ONE) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign line_o = busy_q && (ph_q < PH_HI);
  assign busy_o = busy_q;
  assign done_o = done_q;

  // high-run monitor for the width check
  localparam logic [PW:0] HI_LEN = (PW+1)'(PULSE_CYC);
  logic [PW:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run_q <= '0;
    else if (line_o) hi_run_q <= hi_run_q + 1'b1;
    else hi_run_q <= '0;
  end

  // R6: every emitted pulse lasts exactly PULSE_CYC cycles
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_o) |-> hi_run_q == HI_LEN);

  // R6: a train is never restarted while running
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);

endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNTW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
  localparam logic [CNTW-1:0] LOAD = CNTW'(CYCLES - 1);

  logic [CNTW-1:0] cnt_q;
  logic            busy_q;
  logic            done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        cnt_q  <= LOAD;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R10: completion is reported only when a wait was running
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int CLK_KHZ   = 250000,
  parameter int SETTLE_US = 2000,
  parameter int PULSE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  output logic       req_ready,
  output logic [1:0] cur_mode,
  input  logic       rd_conv,
  input  logic       rd_sck,
  output logic       rd_grant,
  output logic       adc_conv,
  output logic       adc_sck
);
  import pmseq_pkg::*;

  localparam int RAW_SETTLE   = CLK_KHZ * SETTLE_US / 1000;
  localparam int SETTLE_CYC   = (RAW_SETTLE > 0) ? RAW_SETTLE : 1;
  localparam int NAP_PULSES   = 2;
  localparam int SLEEP_PULSES = 4;
  localparam int MAXP         = SLEEP_PULSES;
  localparam int CW           = $clog2(MAXP + 1);
  localparam logic [CW-1:0] N_NAP   = CW'(NAP_PULSES);
  localparam logic [CW-1:0] N_SLEEP = CW'(SLEEP_PULSES);

  seq_st_e  st_q, st_n;
  pm_mode_e tgt_q, tgt_n;
  pm_mode_e mode_q, mode_n;
  logic     from_slp_q, from_slp_n;

  logic          conv_go, sck_go, tmr_go;
  logic [CW-1:0] conv_num;
  logic          conv_line, conv_busy, conv_done;
  logic          sck_line, sck_busy, sck_done;
  logic          tmr_busy, tmr_done;
  logic          accept;
  pm_mode_e      req_m;

  assign req_m     = pm_mode_e'(req_mode);
  assign req_ready = (st_q == ST_ACT) || (st_q == ST_NAP) || (st_q == ST_SLP);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_n       = st_q;
    tgt_n      = tgt_q;
    mode_n     = mode_q;
    from_slp_n = from_slp_q;
    conv_go    = 1'b0;
    conv_num   = N_NAP;
    sck_go     = 1'b0;
    tmr_go     = 1'b0;
    unique case (st_q)
      ST_ACT: if (accept) begin
        if (req_m == PM_NAP) begin
          conv_go = 1'b1; conv_num = N_NAP;   tgt_n = PM_NAP;   st_n = ST_CMD;
        end else if (req_m == PM_SLEEP) begin
          conv_go = 1'b1; conv_num = N_SLEEP; tgt_n = PM_SLEEP; st_n = ST_CMD;
        end
      end
      ST_NAP: if (accept) begin
        if (req_m == PM_SLEEP) begin
          conv_go = 1'b1; conv_num = N_SLEEP; tgt_n = PM_SLEEP; st_n = ST_CMD;
        end else if (req_m == PM_ACTIVE) begin
          sck_go = 1'b1; from_slp_n = 1'b0; tgt_n = PM_ACTIVE; st_n = ST_WAKE;
        end
      end
      ST_SLP: if (accept) begin
        if (req_m == PM_ACTIVE || req_m == PM_NAP) begin
          sck_go = 1'b1; from_slp_n = 1'b1; tgt_n = req_m; st_n = ST_WAKE;
        end
      end
      ST_CMD: if (conv_done) begin
        st_n   = (tgt_q == PM_SLEEP) ? ST_SLP : ST_NAP;
        mode_n = tgt_q;
      end
      ST_WAKE: if (sck_done) begin
        if (from_slp_q) begin
          tmr_go = 1'b1; st_n = ST_SETTLE;
        end else begin
          st_n = ST_ACT; mode_n = PM_ACTIVE;
        end
      end
      ST_SETTLE: if (tmr_done) begin
        if (tgt_q == PM_NAP) begin
          conv_go = 1'b1; conv_num = N_NAP; st_n = ST_CMD;
        end else begin
          st_n = ST_ACT; mode_n = PM_ACTIVE;
        end
      end
      default: st_n = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_ACT;
      tgt_q      <= PM_ACTIVE;
      mode_q     <= PM_ACTIVE;
      from_slp_q <= 1'b0;
    end else begin
      st_q       <= st_n;
      tgt_q      <= tgt_n;
      mode_q     <= mode_n;
      from_slp_q <= from_slp_n;
    end
  end

  pm_pulse_train #(.PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAXP)) u_conv_train (
    .clk(clk), .rst_n(rst_n), .start_i(conv_go), .num_i(conv_num),
    .line_o(conv_line), .busy_o(conv_busy), .done_o(conv_done)
  );

  pm_pulse_train #(.PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAXP)) u_sck_train (
    .clk(clk), .rst_n(rst_n), .start_i(sck_go), .num_i(CW'(1)),
    .line_o(sck_line), .busy_o(sck_busy), .done_o(sck_done)
  );

  pm_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .start_i(tmr_go),
    .busy_o(tmr_busy), .done_o(tmr_done)
  );

  assign rd_grant = (st_q == ST_ACT);
  assign cur_mode = mode_q;
  assign adc_conv = rd_grant ? rd_conv : conv_line;
  assign adc_sck  = rd_grant ? rd_sck  : sck_line;

  // rising-edge count of the convert train, for the burst-length check
  logic          conv_prev_q;
  logic [CW-1:0] rises_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_prev_q <= 1'b0;
      rises_q     <= '0;
    end else begin
      conv_prev_q <= conv_line;
      if (conv_go) rises_q <= '0;
      else if (conv_line && !conv_prev_q) rises_q <= rises_q + 1'b1;
    end
  end

  // R4 R5: burst length matches the target mode
  a_r5_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> rises_q == ((tgt_q == PM_SLEEP) ? N_SLEEP : N_NAP));

  // R4: serial clock still while a convert burst runs
  a_r4_sck_still: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> !adc_sck);

  // R8: lines never granted while any internal activity runs
  a_r8_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy || sck_busy || tmr_busy) |-> !rd_grant);

  // R3: ready only when nothing is in flight
  a_r3_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(conv_busy || sck_busy || tmr_busy));

  // R10: grant never returns while the reference wait runs
  a_r10_grant_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_grant) |-> !tmr_busy);

  // R7: converter lines quiet in a resting low-power state
  a_r7_quiet_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NAP || st_q == ST_SLP) |-> (!adc_conv && !adc_sck));

  // R9: wake pulse never overlaps a convert pulse
  a_r9_wake_alone: assert property (@(posedge clk) disable iff (!rst_n)
    sck_busy |-> !adc_conv);

endmodule

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;
  localparam int P   = 2;
  localparam int KHZ = 250000;
  localparam int US  = 1;
  localparam int SET = KHZ * US / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic rd_conv = 1'b0, rd_sck = 1'b0;
  logic req_ready, rd_grant, adc_conv, adc_sck;
  logic [1:0] cur_mode;

  always #2 clk = ~clk;

  adc_pwr_seq #(.CLK_KHZ(KHZ), .SETTLE_US(US), .PULSE_CYC(P)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_ready(req_ready), .cur_mode(cur_mode), .rd_conv(rd_conv), .rd_sck(rd_sck),
    .rd_grant(rd_grant), .adc_conv(adc_conv), .adc_sck(adc_sck)
  );

  int vectors = 0, miss = 0, cyc = 0;
  bit finished = 0;

  int n_conv, n_sck, bad_w, clash, leak, fall_at, end_at, ready0;
  bit ready_first;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      summary();
    end
  end

  // issue one request and observe the converter lines until resting again
  task automatic run_cmd(input logic [1:0] m, input bit poke);
    int hi = 0, lo = 0, shi = 0;
    logic pc = 0, ps = 0;
    n_conv = 0; n_sck = 0; bad_w = 0; clash = 0; leak = 0;
    fall_at = -1; end_at = -1; ready0 = 0;
    @(negedge clk);
    rd_conv = 1'b1; rd_sck = 1'b1;
    req_mode = m; req_valid = 1'b1;
    ready_first = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (req_ready) begin end_at = c; break; end
      ready0++;
      if (rd_grant) leak++;
      if (adc_conv && adc_sck) clash++;
      if (adc_conv) begin
        if (!pc) begin n_conv++; if (n_conv > 1 && lo != P) bad_w++; hi = 0; end
        hi++;
      end else begin
        if (pc) begin if (hi != P) bad_w++; lo = 0; end
        lo++;
      end
      if (adc_sck) begin
        if (!ps) begin n_sck++; shi = 0; end
        shi++;
      end else if (ps) begin
        if (shi != P) bad_w++;
        fall_at = c;
      end
      pc = adc_conv; ps = adc_sck;
      if (poke && c == 3) begin req_mode = 2'b00; req_valid = 1'b1; end
      if (poke && c == 5) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic quiet_check(input string req);
    @(negedge clk);
    rd_conv = 1'b1; rd_sck = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!adc_conv && !adc_sck, req, {adc_conv, adc_sck}, 0);
    end
    rd_conv = 1'b0; rd_sck = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rd_grant == 1'b1, "R1 grant", rd_grant, 1);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(cur_mode == 2'b00, "R1 mode", cur_mode, 0);
    rd_conv = 1'b1; rd_sck = 1'b0;
    @(negedge clk);
    chk(adc_conv == 1'b1 && adc_sck == 1'b0, "R1 follow", {adc_conv, adc_sck}, 2);
  endtask

  task automatic t_pass();
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      rd_conv = v[0]; rd_sck = v[1];
      #1;
      chk(adc_conv == rd_conv && adc_sck == rd_sck, "R2 passthrough",
          {adc_conv, adc_sck}, {rd_conv, rd_sck});
    end
    rd_conv = 1'b0; rd_sck = 1'b0;
  endtask

  task automatic t_nap(input string tag);
    run_cmd(2'b01, 0);
    chk(ready_first == 1'b1, "R3 ready before nap", ready_first, 1);
    chk(n_conv == 2, {"R4 nap pulses ", tag}, n_conv, 2);
    chk(n_sck == 0, "R4 sck still", n_sck, 0);
    chk(bad_w == 0, "R6 widths nap", bad_w, 0);
    chk(leak == 0, "R8 no grant in nap cmd", leak, 0);
    chk(cur_mode == 2'b01, "R4 mode nap", cur_mode, 1);
    chk(rd_grant == 1'b0, "R8 grant low in nap", rd_grant, 0);
    quiet_check("R7 nap lines quiet");
  endtask

  task automatic t_keep();
    run_cmd(2'b01, 0);
    chk(end_at == 0 && n_conv == 0 && n_sck == 0, "R12 same mode", n_conv + n_sck, 0);
    run_cmd(2'b11, 0);
    chk(end_at == 0 && n_conv == 0 && n_sck == 0, "R12 keep code", n_conv + n_sck, 0);
    chk(cur_mode == 2'b01 && rd_grant == 1'b0, "R12 mode held", cur_mode, 1);
    rd_conv = 1'b0; rd_sck = 1'b0;
  endtask

  task automatic t_wake_nap();
    run_cmd(2'b00, 0);
    chk(n_sck == 1, "R9 one wake pulse", n_sck, 1);
    chk(n_conv == 0, "R9 conv low", n_conv, 0);
    chk(bad_w == 0, "R9 wake width", bad_w, 0);
    chk(end_at - fall_at <= P + 2 && fall_at >= 0, "R9 no wait", end_at - fall_at, P + 2);
    @(negedge clk);
    chk(rd_grant == 1'b1 && cur_mode == 2'b00, "R9 active again", rd_grant, 1);
    rd_conv = 1'b0; rd_sck = 1'b0;
  endtask

  task automatic t_sleep(input bit poke, input string tag);
    run_cmd(2'b10, poke);
    chk(n_conv == 4, {"R5 sleep pulses ", tag}, n_conv, 4);
    chk(n_sck == 0 && clash == 0, "R5 sck still", n_sck, 0);
    chk(bad_w == 0, "R6 widths sleep", bad_w, 0);
    chk(cur_mode == 2'b10, "R5 mode sleep", cur_mode, 2);
    if (poke) chk(cur_mode == 2'b10 && ready0 > 6, "R3 busy request ignored", cur_mode, 2);
    quiet_check("R7 sleep lines quiet");
  endtask

  task automatic t_wake_sleep();
    run_cmd(2'b00, 0);
    chk(n_sck == 1 && n_conv == 0, "R10 one wake pulse", n_sck, 1);
    chk(end_at - fall_at >= SET, "R10 wait long enough", end_at - fall_at, SET);
    chk(end_at - fall_at <= SET + 2 * P + 2, "R10 wait bounded", end_at - fall_at, SET + 2 * P + 2);
    chk(leak == 0, "R8 no grant during wait", leak, 0);
    @(negedge clk);
    chk(rd_grant == 1'b1 && cur_mode == 2'b00, "R10 active again", rd_grant, 1);
    rd_conv = 1'b0; rd_sck = 1'b0;
  endtask

  task automatic t_sleep_to_nap();
    run_cmd(2'b01, 0);
    chk(n_sck == 1, "R11 wake pulse", n_sck, 1);
    chk(n_conv == 2, "R11 nap pulses", n_conv, 2);
    chk(ready0 >= SET, "R11 waited", ready0, SET);
    chk(leak == 0 && clash == 0, "R11 grant stays low", leak, 0);
    chk(cur_mode == 2'b01, "R11 rests in nap", cur_mode, 1);
    rd_conv = 1'b0; rd_sck = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    t_nap("from active");
    t_keep();
    t_wake_nap();
    t_sleep(1, "from active");
    t_wake_sleep();
    t_nap("again");
    t_sleep(0, "from nap");
    t_sleep_to_nap();
    t_wake_nap();
    t_pass();
    summary();
  end
endmodule